// File: doc/BRIEF.md
# Row-Fragment Cache with Width Adapter

This block sits at the processor-facing end of a stacked-DRAM channel controller and runs entirely on the system clock. The front end issues narrow reads and writes. The DRAM side moves one wide word per command. The block keeps a single wide register that holds the row fragment touched by the last downstream fill. Its tag is the wide-word-aligned address, and it carries a valid flag and a dirty flag.

A read whose wide-aligned address matches the held fragment is answered from the register, and no downstream traffic results. A write that matches is merged into the fragment under its byte enables and marks the fragment dirty. Merged writes therefore gather in the register and leave as one wide transfer later. A request that does not match is held off at the front end. If the fragment is dirty, the block first writes it back as a wide write command. It then issues a wide read command for the missing fragment and loads the returned data. The held request then completes as an ordinary hit.

Every data path uses a valid/ready handshake. A source keeps valid asserted and its payload unchanged until the transfer, which happens on a clock edge where both valid and ready are high. The front-end request must stay stable while `fe_req_ready` is low. The block holds `dn_cmd_*` while `dn_cmd_ready` is low, and it holds `fe_rsp_*` while `fe_rsp_ready` is low. The downstream read return is accepted only while a fill is outstanding.

Top module: `row_frag_cache`

## Requirements
- R1: After reset the fragment is invalid: `fe_rsp_valid` and `dn_cmd_valid` are low, and `fe_req_ready` is low for any address, because the first access always misses.
- R2: The narrow address splits into a tag, made of the upper ADDR_W-log2(RATIO) bits, and a lane index, made of the low log2(RATIO) bits. Lane i of a wide word occupies bits [i*NARROW_W +: NARROW_W]. A read returns the lane its index selects.
- R3: A read hit is accepted in the cycle it is presented, and `fe_rsp_valid` rises on the following clock with the selected lane. No downstream command is issued for it.
- R4: A write hit is accepted in one cycle, issues no downstream command and produces no response. Bit j of `fe_req_be` replaces byte j, meaning bits [8j+7:8j], of the addressed lane, and all other bytes keep their value.
- R5: When a request misses on a clean or invalid fragment, the block issues exactly one read command (`dn_cmd_write`=0) whose `dn_cmd_addr` is the request's tag. If the request was presented in an idle cycle, `dn_cmd_valid` rises on the next clock.
- R6: Data accepted on the downstream return (`dn_rd_valid` and `dn_rd_ready`) becomes the fragment, and the held request then completes as a hit.
- R7: When a request misses on a dirty fragment, the block first issues a write command (`dn_cmd_write`=1) carrying the old tag and the whole merged wide word, and only then issues the read command.
- R8: `dn_cmd_valid` and its payload stay stable while `dn_cmd_ready` is low. `fe_rsp_valid` and `fe_rsp_data` stay stable while `fe_rsp_ready` is low.
- R9: `fe_req_ready` stays low while a downstream command, a fill or a response is outstanding.
- R10: A read returns the most recent data written to that narrow address, whether the data is still in the fragment or has been written back and re-fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fe_req_valid | input | 1 | Front-end request valid |
| fe_req_ready | output | 1 | Request accepted on this edge (hit and idle) |
| fe_req_write | input | 1 | 1 = write, 0 = read |
| fe_req_addr | input | ADDR_W | Narrow-word address |
| fe_req_wdata | input | NARROW_W | Write data |
| fe_req_be | input | NARROW_W/8 | Byte enables for writes |
| fe_rsp_valid | output | 1 | Read response valid |
| fe_rsp_ready | input | 1 | Front end takes the response |
| fe_rsp_data | output | NARROW_W | Read response data |
| dn_cmd_valid | output | 1 | Wide command valid |
| dn_cmd_ready | input | 1 | Downstream queue accepts the command |
| dn_cmd_write | output | 1 | 1 = write-back, 0 = fetch |
| dn_cmd_addr | output | ADDR_W-log2(RATIO) | Wide-word address (tag) |
| dn_cmd_wdata | output | NARROW_W*RATIO | Write-back data |
| dn_rd_valid | input | 1 | Fetched wide data valid |
| dn_rd_ready | output | 1 | Block waits for fetched data |
| dn_rd_data | input | NARROW_W*RATIO | Fetched wide data |

## Verification
The bench builds the block with its defaults: an 8-bit narrow address, 32-bit lanes and a ratio of four. This gives a 128-bit fragment and 64 distinct tags. With that small tag space, the bench's model memory can give every wide word and every lane a distinct pattern. A handful of addresses is then enough to force clean evictions, dirty write-backs and the re-fetch of previously written data. The bench stalls the command and response sides for several cycles. This shows that payloads are held and that the front end is blocked during a miss.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  typedef enum logic [2:0] {
    RFC_IDLE,
    RFC_EVICT,
    RFC_FETCH,
    RFC_WAIT,
    RFC_REPLY
  } rfc_state_e;
endpackage

// File: rtl/rfc_frag_store.sv
module rfc_frag_store #(
  parameter int NARROW_W = 32,
  parameter int RATIO    = 4,
  parameter int TAG_W    = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         merge_en,
  input  logic [$clog2(RATIO)-1:0]     merge_idx,
  input  logic [NARROW_W-1:0]          merge_data,
  input  logic [NARROW_W/8-1:0]        merge_be,
  input  logic                         fill_en,
  input  logic [TAG_W-1:0]             fill_tag,
  input  logic [NARROW_W*RATIO-1:0]    fill_data,
  input  logic                         clean_en,
  output logic [NARROW_W*RATIO-1:0]    frag_data,
  output logic [TAG_W-1:0]             frag_tag,
  output logic                         frag_valid,
  output logic                         frag_dirty
);
  localparam int BYTES  = NARROW_W / 8;
  localparam int WIDE_W = NARROW_W * RATIO;

  logic [WIDE_W-1:0] nxt_data;

  // per-byte next value: fill wins, then a merge into the selected lane
  for (genvar g = 0; g < RATIO; g++) begin : g_lane
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
      localparam int LO = g * NARROW_W + b * 8;
      assign nxt_data[LO +: 8] =
        fill_en ? fill_data[LO +: 8] :
        (merge_en && (merge_idx == g[$clog2(RATIO)-1:0]) && merge_be[b]) ?
          merge_data[b*8 +: 8] : frag_data[LO +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frag_data  <= '0;
      frag_tag   <= '0;
      frag_valid <= 1'b0;
      frag_dirty <= 1'b0;
    end else begin
      frag_data <= nxt_data;
      if (fill_en) begin
        frag_tag   <= fill_tag;
        frag_valid <= 1'b1;
        frag_dirty <= 1'b0;
      end else if (merge_en) begin
        frag_dirty <= 1'b1;
      end else if (clean_en) begin
        frag_dirty <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rfc_lane_sel.sv
module rfc_lane_sel #(
  parameter int NARROW_W = 32,
  parameter int RATIO    = 4
) (
  input  logic [NARROW_W*RATIO-1:0] wide,
  input  logic [$clog2(RATIO)-1:0]  idx,
  output logic [NARROW_W-1:0]       lane
);
  logic [NARROW_W-1:0] lanes [RATIO];

  for (genvar g = 0; g < RATIO; g++) begin : g_split
    assign lanes[g] = wide[g*NARROW_W +: NARROW_W];
  end

  assign lane = lanes[idx];
endmodule

// File: rtl/rfc_ctrl.sv
module rfc_ctrl
  import rfc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic hit,
  input  logic dirty,
  input  logic cmd_ready,
  input  logic rd_valid,
  input  logic rsp_ready,
  output logic req_ready,
  output logic rsp_valid,
  output logic cmd_valid,
  output logic cmd_write,
  output logic rd_ready,
  output logic fill_en,
  output logic clean_en,
  output logic miss_cap,
  output logic reply_cap
);
  rfc_state_e state, nxt;

  always_comb begin
    nxt       = state;
    req_ready = 1'b0;
    rsp_valid = 1'b0;
    cmd_valid = 1'b0;
    cmd_write = 1'b0;
    rd_ready  = 1'b0;
    fill_en   = 1'b0;
    clean_en  = 1'b0;
    miss_cap  = 1'b0;
    reply_cap = 1'b0;
    unique case (state)
      RFC_IDLE: begin
        req_ready = hit;
        if (req_valid) begin
          if (hit) begin
            if (!req_write) begin
              reply_cap = 1'b1;
              nxt       = RFC_REPLY;
            end
          end else begin
            miss_cap = 1'b1;
            nxt      = dirty ? RFC_EVICT : RFC_FETCH;
          end
        end
      end
      RFC_EVICT: begin
        cmd_valid = 1'b1;
        cmd_write = 1'b1;
        if (cmd_ready) begin
          clean_en = 1'b1;
          nxt      = RFC_FETCH;
        end
      end
      RFC_FETCH: begin
        cmd_valid = 1'b1;
        if (cmd_ready) nxt = RFC_WAIT;
      end
      RFC_WAIT: begin
        rd_ready = 1'b1;
        if (rd_valid) begin
          fill_en = 1'b1;
          nxt     = RFC_IDLE;
        end
      end
      RFC_REPLY: begin
        rsp_valid = 1'b1;
        if (rsp_ready) nxt = RFC_IDLE;
      end
      default: nxt = RFC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= RFC_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/row_frag_cache.sv
module row_frag_cache #(
  parameter int ADDR_W   = 8,
  parameter int NARROW_W = 32,
  parameter int RATIO    = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                fe_req_valid,
  output logic                                fe_req_ready,
  input  logic                                fe_req_write,
  input  logic [ADDR_W-1:0]                   fe_req_addr,
  input  logic [NARROW_W-1:0]                 fe_req_wdata,
  input  logic [NARROW_W/8-1:0]               fe_req_be,
  output logic                                fe_rsp_valid,
  input  logic                                fe_rsp_ready,
  output logic [NARROW_W-1:0]                 fe_rsp_data,
  output logic                                dn_cmd_valid,
  input  logic                                dn_cmd_ready,
  output logic                                dn_cmd_write,
  output logic [ADDR_W-$clog2(RATIO)-1:0]     dn_cmd_addr,
  output logic [NARROW_W*RATIO-1:0]           dn_cmd_wdata,
  input  logic                                dn_rd_valid,
  output logic                                dn_rd_ready,
  input  logic [NARROW_W*RATIO-1:0]           dn_rd_data
);
  localparam int SEL_W  = $clog2(RATIO);
  localparam int TAG_W  = ADDR_W - SEL_W;
  localparam int WIDE_W = NARROW_W * RATIO;

  logic [TAG_W-1:0]  req_tag, miss_tag, frag_tag;
  logic [SEL_W-1:0]  req_idx, rsp_idx;
  logic [WIDE_W-1:0] frag_data;
  logic              frag_valid, frag_dirty, hit;
  logic              fill_en, clean_en, miss_cap, reply_cap, merge_en;

  assign req_tag  = fe_req_addr[ADDR_W-1:SEL_W];
  assign req_idx  = fe_req_addr[SEL_W-1:0];
  assign hit      = frag_valid && (frag_tag == req_tag);
  assign merge_en = fe_req_valid && fe_req_ready && fe_req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_tag <= '0;
      rsp_idx  <= '0;
    end else begin
      if (miss_cap)  miss_tag <= req_tag;
      if (reply_cap) rsp_idx  <= req_idx;
    end
  end

  rfc_ctrl i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (fe_req_valid),
    .req_write (fe_req_write),
    .hit       (hit),
    .dirty     (frag_dirty),
    .cmd_ready (dn_cmd_ready),
    .rd_valid  (dn_rd_valid),
    .rsp_ready (fe_rsp_ready),
    .req_ready (fe_req_ready),
    .rsp_valid (fe_rsp_valid),
    .cmd_valid (dn_cmd_valid),
    .cmd_write (dn_cmd_write),
    .rd_ready  (dn_rd_ready),
    .fill_en   (fill_en),
    .clean_en  (clean_en),
    .miss_cap  (miss_cap),
    .reply_cap (reply_cap)
  );

  rfc_frag_store #(
    .NARROW_W (NARROW_W),
    .RATIO    (RATIO),
    .TAG_W    (TAG_W)
  ) i_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .merge_en   (merge_en),
    .merge_idx  (req_idx),
    .merge_data (fe_req_wdata),
    .merge_be   (fe_req_be),
    .fill_en    (fill_en),
    .fill_tag   (miss_tag),
    .fill_data  (dn_rd_data),
    .clean_en   (clean_en),
    .frag_data  (frag_data),
    .frag_tag   (frag_tag),
    .frag_valid (frag_valid),
    .frag_dirty (frag_dirty)
  );

  rfc_lane_sel #(
    .NARROW_W (NARROW_W),
    .RATIO    (RATIO)
  ) i_lane (
    .wide (frag_data),
    .idx  (rsp_idx),
    .lane (fe_rsp_data)
  );

  assign dn_cmd_addr  = dn_cmd_write ? frag_tag : miss_tag;
  assign dn_cmd_wdata = frag_data;
endmodule

// File: rtl/rfc_checker.sv
module rfc_checker #(
  parameter int ADDR_W   = 8,
  parameter int NARROW_W = 32,
  parameter int RATIO    = 4
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            fe_req_valid,
  input logic                            fe_req_ready,
  input logic                            fe_req_write,
  input logic [ADDR_W-1:0]               fe_req_addr,
  input logic [NARROW_W-1:0]             fe_req_wdata,
  input logic [NARROW_W/8-1:0]           fe_req_be,
  input logic                            fe_rsp_valid,
  input logic                            fe_rsp_ready,
  input logic [NARROW_W-1:0]             fe_rsp_data,
  input logic                            dn_cmd_valid,
  input logic                            dn_cmd_ready,
  input logic                            dn_cmd_write,
  input logic [ADDR_W-$clog2(RATIO)-1:0] dn_cmd_addr,
  input logic [NARROW_W*RATIO-1:0]       dn_cmd_wdata,
  input logic                            dn_rd_valid,
  input logic                            dn_rd_ready,
  input logic [NARROW_W*RATIO-1:0]       dn_rd_data
);
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dn_cmd_valid && !dn_cmd_ready |=> dn_cmd_valid && $stable(dn_cmd_write)
      && $stable(dn_cmd_addr) && $stable(dn_cmd_wdata)); // R8

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fe_rsp_valid && !fe_rsp_ready |=> fe_rsp_valid && $stable(fe_rsp_data)); // R8

  AST_BLOCK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_cmd_valid || dn_rd_ready || fe_rsp_valid) |-> !fe_req_ready); // R9

  AST_READ_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    fe_req_valid && fe_req_ready && !fe_req_write |=> fe_rsp_valid && !dn_cmd_valid); // R3

  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    fe_req_valid && fe_req_ready && fe_req_write |=> !dn_cmd_valid && !fe_rsp_valid); // R4

  AST_MISS_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
    fe_req_valid && !fe_req_ready && !fe_rsp_valid && !dn_cmd_valid && !dn_rd_ready
      |=> dn_cmd_valid); // R5

  AST_EVICT_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    dn_cmd_valid && dn_cmd_ready && dn_cmd_write |=> dn_cmd_valid && !dn_cmd_write); // R7

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({dn_cmd_valid, dn_rd_ready, fe_rsp_valid}) <= 1); // R9
endmodule

bind row_frag_cache rfc_checker #(
  .ADDR_W   (ADDR_W),
  .NARROW_W (NARROW_W),
  .RATIO    (RATIO)
) i_rfc_checker (.*);

// File: tb/test_row_frag_cache.sv
module test_row_frag_cache;
  localparam int ADDR_W = 8, NW = 32, RATIO = 4, SEL_W = 2;
  localparam int TAG_W = ADDR_W - SEL_W, WW = NW * RATIO, BEW = NW / 8;
  localparam int DEPTH = 1 << TAG_W;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic fe_req_valid, fe_req_ready, fe_req_write;
  logic [ADDR_W-1:0] fe_req_addr;
  logic [NW-1:0] fe_req_wdata, fe_rsp_data;
  logic [BEW-1:0] fe_req_be;
  logic fe_rsp_valid, fe_rsp_ready;
  logic dn_cmd_valid, dn_cmd_ready, dn_cmd_write;
  logic [TAG_W-1:0] dn_cmd_addr;
  logic [WW-1:0] dn_cmd_wdata, dn_rd_data;
  logic dn_rd_valid, dn_rd_ready;

  row_frag_cache #(.ADDR_W(ADDR_W), .NARROW_W(NW), .RATIO(RATIO)) i_row_frag_cache (
    .clk(clk), .rst_n(rst_n),
    .fe_req_valid(fe_req_valid), .fe_req_ready(fe_req_ready), .fe_req_write(fe_req_write),
    .fe_req_addr(fe_req_addr), .fe_req_wdata(fe_req_wdata), .fe_req_be(fe_req_be),
    .fe_rsp_valid(fe_rsp_valid), .fe_rsp_ready(fe_rsp_ready), .fe_rsp_data(fe_rsp_data),
    .dn_cmd_valid(dn_cmd_valid), .dn_cmd_ready(dn_cmd_ready), .dn_cmd_write(dn_cmd_write),
    .dn_cmd_addr(dn_cmd_addr), .dn_cmd_wdata(dn_cmd_wdata),
    .dn_rd_valid(dn_rd_valid), .dn_rd_ready(dn_rd_ready), .dn_rd_data(dn_rd_data)
  );

  logic [WW-1:0] dram [DEPTH];
  logic [WW-1:0] gold [DEPTH];
  logic [NW-1:0] exp_q [$];
  int checks = 0, errors = 0, n_rd_cmd = 0, n_wr_cmd = 0, busy_bad = 0;
  int cmd_stall = 0, rsp_stall = 0, cycles = 0;

  function automatic logic [WW-1:0] seed_word(int t);
    logic [WW-1:0] w;
    for (int l = 0; l < RATIO; l++) w[l*NW +: NW] = {8'hA5, 8'(t), 8'h3C, 8'(l)};
    return w;
  endfunction

  task automatic check(bit ok, string req, logic [WW-1:0] act, logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      check(0, "R9 watchdog", WW'(cycles), WW'(20000));
      finish_run();
    end
  end

  // downstream model and response monitor, driven on the falling edge
  logic snap_cmd, snap_cmd_w, snap_rd, snap_rsp, hold_rsp, hold_cmd, prev_was_wr;
  logic [TAG_W-1:0] snap_addr, pend_addr;
  logic [WW-1:0] snap_wdata;
  logic [NW-1:0] snap_rsp_data;
  logic pend;
  int delay;

  always @(negedge clk) begin : mon
    logic [NW-1:0] e;
    if (!rst_n) begin
      snap_cmd = 0; snap_rd = 0; snap_rsp = 0; hold_rsp = 0; hold_cmd = 0;
      prev_was_wr = 0; pend = 0; delay = 0;
      dn_rd_valid = 0; dn_rd_data = '0; dn_cmd_ready = 1; fe_rsp_ready = 1;
    end else begin
      if (hold_rsp) check(fe_rsp_valid && fe_rsp_data == snap_rsp_data, "R8 rsp hold",
                          WW'(fe_rsp_data), WW'(snap_rsp_data));
      if (hold_cmd) check(dn_cmd_valid && dn_cmd_addr == snap_addr && dn_cmd_write == snap_cmd_w,
                          "R8 cmd hold", WW'(dn_cmd_addr), WW'(snap_addr));
      if (snap_rd) dn_rd_valid = 0;
      if (snap_cmd) begin
        if (prev_was_wr) check(!snap_cmd_w, "R7 fetch follows write-back", WW'(snap_cmd_w), '0);
        prev_was_wr = snap_cmd_w;
        if (snap_cmd_w) begin
          dram[snap_addr] = snap_wdata;
          n_wr_cmd++;
        end else begin
          n_rd_cmd++;
          pend = 1; pend_addr = snap_addr; delay = 2;
        end
      end
      if (snap_rsp) begin
        if (exp_q.size() == 0) check(0, "R3 unexpected response", WW'(snap_rsp_data), '0);
        else begin
          e = exp_q.pop_front();
          check(snap_rsp_data == e, "R3 R10 read data", WW'(snap_rsp_data), WW'(e));
        end
      end
      if (pend && !dn_rd_valid) begin
        if (delay > 0) delay--;
        else begin
          dn_rd_valid = 1; dn_rd_data = dram[pend_addr]; pend = 0;
        end
      end
      dn_cmd_ready = (cmd_stall == 0);
      if (cmd_stall > 0 && dn_cmd_valid) cmd_stall--;
      fe_rsp_ready = (rsp_stall == 0);
      if (rsp_stall > 0 && fe_rsp_valid) rsp_stall--;
    end
    #1;
    snap_cmd   = dn_cmd_valid && dn_cmd_ready;
    hold_cmd   = rst_n && dn_cmd_valid && !dn_cmd_ready;
    snap_cmd_w = dn_cmd_write;
    snap_addr  = dn_cmd_addr;
    snap_wdata = dn_cmd_wdata;
    snap_rd    = dn_rd_valid && dn_rd_ready;
    snap_rsp   = fe_rsp_valid && fe_rsp_ready;
    hold_rsp   = rst_n && fe_rsp_valid && !fe_rsp_ready;
    snap_rsp_data = fe_rsp_data;
    if (rst_n && dn_cmd_valid && fe_req_ready) busy_bad++;
  end

  // front-end driver: pushes expected read data into the scoreboard
  task automatic req(bit w, logic [ADDR_W-1:0] a, logic [NW-1:0] d, logic [BEW-1:0] be);
    logic [TAG_W-1:0] t;
    logic [SEL_W-1:0] ix;
    @(negedge clk);
    fe_req_valid = 1; fe_req_write = w; fe_req_addr = a; fe_req_wdata = d; fe_req_be = be;
    forever begin
      #2;
      if (fe_req_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    t = a[ADDR_W-1:SEL_W];
    ix = a[SEL_W-1:0];
    if (w) begin
      for (int b = 0; b < BEW; b++)
        if (be[b]) gold[t][ix*NW + b*8 +: 8] = d[b*8 +: 8];
    end else begin
      exp_q.push_back(gold[t][ix*NW +: NW]);
    end
    #1 fe_req_valid = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      dram[i] = seed_word(i);
      gold[i] = seed_word(i);
    end
    rst_n = 0; fe_req_valid = 0; fe_req_write = 0; fe_req_addr = '0;
    fe_req_wdata = '0; fe_req_be = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    check(!fe_rsp_valid, "R1 rsp_valid after reset", WW'(fe_rsp_valid), '0);
    check(!dn_cmd_valid, "R1 cmd_valid after reset", WW'(dn_cmd_valid), '0);
    check(!fe_req_ready, "R1 ready low on empty fragment", WW'(fe_req_ready), '0);

    // R5 R6: clean miss, fill, then served
    req(0, 8'h05, '0, '0); drain();
    check(n_rd_cmd == 1 && n_wr_cmd == 0, "R5 single fetch", WW'(n_rd_cmd), WW'(1));

    // R2 R3: other lanes of the same fragment hit
    req(0, 8'h04, '0, '0); req(0, 8'h06, '0, '0); req(0, 8'h07, '0, '0); drain();
    check(n_rd_cmd == 1, "R3 hits issue no command", WW'(n_rd_cmd), WW'(1));

    // R4: byte-enabled merge
    req(1, 8'h06, 32'hDEADBEEF, 4'b0101);
    req(0, 8'h06, '0, '0); drain();
    check(n_rd_cmd == 1 && n_wr_cmd == 0, "R4 write hit silent", WW'(n_rd_cmd + n_wr_cmd), WW'(1));

    // R7: dirty eviction
    req(0, 8'h20, '0, '0); drain();
    check(n_wr_cmd == 1, "R7 one write-back", WW'(n_wr_cmd), WW'(1));
    check(dram[1] == gold[1], "R7 write-back data", dram[1], gold[1]);
    check(n_rd_cmd == 2, "R7 fetch after write-back", WW'(n_rd_cmd), WW'(2));

    // R8: back-pressure on both sides, clean eviction
    cmd_stall = 3; rsp_stall = 3;
    req(0, 8'h43, '0, '0); drain();
    check(n_rd_cmd == 3 && n_wr_cmd == 1, "R5 clean miss no write-back", WW'(n_wr_cmd), WW'(1));

    // R6 R4: write miss allocates then merges
    req(1, 8'h81, 32'h12345678, 4'b1111);
    req(0, 8'h81, '0, '0); req(0, 8'h80, '0, '0); drain();
    check(n_rd_cmd == 4 && n_wr_cmd == 1, "R6 write miss fetch", WW'(n_rd_cmd), WW'(4));

    // R10: evict written data and read it back from memory
    req(1, 8'h83, 32'hCAFE0000, 4'b1000);
    req(0, 8'hF2, '0, '0); drain();
    check(dram[8'h83 >> SEL_W] == gold[8'h83 >> SEL_W], "R7 merged write-back",
          dram[8'h83 >> SEL_W], gold[8'h83 >> SEL_W]);
    req(0, 8'h83, '0, '0); req(0, 8'h81, '0, '0); drain();
    check(n_rd_cmd == 6 && n_wr_cmd == 2, "R10 refetch counts", WW'(n_rd_cmd), WW'(6));

    // R2 R6: sweep lanes across several fragments
    for (int t = 10; t < 14; t++)
      for (int l = RATIO - 1; l >= 0; l--) req(0, ADDR_W'(t * RATIO + l), '0, '0);
    drain();
    check(n_rd_cmd == 10, "R2 sweep fetch count", WW'(n_rd_cmd), WW'(10));

    check(busy_bad == 0, "R9 no accept while command pending", WW'(busy_bad), '0);
    check(exp_q.size() == 0, "R3 all responses seen", WW'(exp_q.size()), '0);
    finish_run();
  end
endmodule